// File: doc/BRIEF.md
# Retriggerable Transmit-Enable One-Shot

This block generates the driver-enable signal for a half-duplex RS-485 transceiver. It watches only the serial transmit line. The enable rises as soon as the line drops at a start bit. Every low level on the line restarts a hold counter, so the enable stays on across back-to-back characters.

The counter steps only on the transmitter's own bit-rate clock enable, and never on the fast system clock. The turn-off delay is therefore a fixed number of bit periods at any baud rate. The hold setting comes from an input. It should cover one worst-case character: a start bit followed by nine high bits (eight data bits and the stop bit). With that setting the enable drops within one character time after the last stop bit.

The transmit line passes through a synchroniser before it is used. The enable leaves the block straight from a flop, so it cannot glitch.

Top module: `txen_oneshot`

## Requirements
- R1: After reset is released, `drv_en` is 0 and the line is treated as idle, even if no clock enable arrives.
- R2: A low level on `txd` sets `drv_en` to 1 exactly three `clk` rising edges after the line falls: two synchroniser stages plus the output register.
- R3: While the synchronised line is low, the hold counter is reloaded on every `clk` edge, whatever the state of `tick`.
- R4: While the synchronised line is high, the hold counter decrements by one on each `clk` edge where `tick` is 1. `drv_en` falls on the edge that brings it to 0, which is the `hold_cfg`-th tick counted from the first edge after the synchronised line rose.
- R5: While the synchronised line is high and `tick` is 0, the counter and `drv_en` keep their values, however many `clk` cycles pass.
- R6: A low level that arrives during a countdown restarts the full hold, so ticks counted before it are discarded.
- R7: A `hold_cfg` value of 0 behaves as 1, so the enable drops on the first tick.
- R8: The largest `hold_cfg` value (all ones) gives exactly that many ticks of hold.
- R9: For an 8N1 character with bit-rate ticks and `hold_cfg` = 10, `drv_en` stays 1 from its rise until the stop bit ends, then falls within one character time (10 ticks). In this character format `txd` is low for the start bit, then carries the data bits LSB first, then is high for the stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Transmitter bit-rate clock enable, one `clk` wide |
| txd | input | 1 | Serial transmit data, idle high |
| hold_cfg | input | HOLD_W | Hold length in ticks after the last low bit; 0 acts as 1 |
| drv_en | output | 1 | Registered driver enable for the transceiver |

## Verification
The bench builds the block with `HOLD_W` = 4. This makes the all-ones setting (15 ticks) short enough to count out tick by tick next to the zero setting, which is raised to 1. It keeps `SYNC_STAGES` at 2, so the three-edge turn-on latency is measured directly. The tick input is under direct bench control, so long stretches without any tick can show that the countdown freezes, and a retrigger can be placed at an exact point in a countdown. A full 0xFF character, whose only zero is the start bit, is driven at one tick per bit. It covers the case where the hold must bridge eight data bits and the stop bit.

// File: rtl/txen_pkg.sv
package txen_pkg;
    // Idle level of an asynchronous serial line.
    localparam logic LINE_IDLE = 1'b1;
endpackage

// File: rtl/txen_sync.sv
module txen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    import txen_pkg::*;

    typedef struct packed {
        logic [STAGES-1:0] sr;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.sr = {s_q.sr[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{sr: {STAGES{LINE_IDLE}}};
        else        s_q <= s_d;
    end

    assign dout = s_q.sr[STAGES-1];

    // R1: the synchronised line reads idle right after reset.
    always_ff @(posedge clk) begin
        if (rst_n && $past(!rst_n)) begin
            assert_sync_idle_R1: assert (dout == LINE_IDLE)
                else $error("synchroniser not idle after reset");
        end
    end
endmodule

// File: rtl/txen_hold_sat.sv
module txen_hold_sat #(
    parameter int HOLD_W = 8
) (
    input  logic [HOLD_W-1:0] cfg,
    output logic [HOLD_W-1:0] load_val
);
    // A zero setting is raised to one tick.
    always_comb begin
        load_val = cfg;
        if (cfg == '0) load_val = HOLD_W'(1);
    end

    always_comb begin
        assert_load_nonzero_R7: assert (load_val != '0)
            else $error("hold load value is zero");
    end
endmodule

// File: rtl/txen_hold_ctr.sv
module txen_hold_ctr #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line,
    input  logic              tick,
    input  logic [HOLD_W-1:0] load_val,
    output logic              en
);
    typedef struct packed {
        logic [HOLD_W-1:0] cnt;
        logic              en;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (!line) begin
            h_d.cnt = load_val;
        end else if (tick && (h_q.cnt != '0)) begin
            h_d.cnt = h_q.cnt - HOLD_W'(1);
        end
        h_d.en = (h_d.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign en = h_q.en;

    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !line |=> (h_q.cnt == $past(load_val)));

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (line && tick && h_q.cnt != '0) |=> (h_q.cnt == $past(h_q.cnt) - HOLD_W'(1)));

    assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line && !tick) |=> ($stable(h_q.cnt) && $stable(h_q.en)));

    assert_fall_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(h_q.en) |-> ($past(tick) && $past(line)));
endmodule

// File: rtl/txen_oneshot.sv
module txen_oneshot #(
    parameter int HOLD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              txd,
    input  logic [HOLD_W-1:0] hold_cfg,
    output logic              drv_en
);
    logic              line_s;
    logic [HOLD_W-1:0] load_val;

    txen_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (txd),
        .dout (line_s)
    );

    txen_hold_sat #(.HOLD_W(HOLD_W)) i_sat (
        .cfg     (hold_cfg),
        .load_val(load_val)
    );

    txen_hold_ctr #(.HOLD_W(HOLD_W)) i_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .line    (line_s),
        .tick    (tick),
        .load_val(load_val),
        .en      (drv_en)
    );

    assert_low_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !line_s |=> drv_en);

    assert_reset_off_R1: assert property (@(posedge clk)
        !rst_n |=> !drv_en);
endmodule

// File: tb/test_txen_oneshot.sv
module test_txen_oneshot;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         txd = 1'b1;
    logic [W-1:0] hold_cfg = W'(8);
    logic         drv_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    txen_oneshot #(.HOLD_W(W), .SYNC_STAGES(2)) i_txen_oneshot (
        .clk(clk), .rst_n(rst_n), .tick(tick), .txd(txd),
        .hold_cfg(hold_cfg), .drv_en(drv_en)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: drv_en=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    // Line low long enough to be seen, then high and synchronised.
    task automatic low_then_high(input int low_cyc);
        txd = 1'b0;
        cyc(low_cyc);
        txd = 1'b1;
        cyc(2);
    endtask

    task automatic t_reset;
        cyc(5);
        chk("R1 reset", drv_en, 1'b0);
        rst_n = 1'b1;
        cyc(20);
        chk("R1 idle after reset", drv_en, 1'b0);
    endtask

    task automatic t_latency;
        hold_cfg = W'(3);
        txd = 1'b0;
        cyc(2);
        chk("R2 two edges", drv_en, 1'b0);
        cyc(1);
        chk("R2 third edge", drv_en, 1'b1);
        tick = 1'b1;
        cyc(3);
        chk("R3 ticks ignored while low", drv_en, 1'b1);
        tick = 1'b0;
        txd = 1'b1;
        cyc(2);
        pulse(); pulse();
        chk("R4 before last tick", drv_en, 1'b1);
        pulse();
        chk("R4 last tick", drv_en, 1'b0);
    endtask

    task automatic t_freeze;
        hold_cfg = W'(2);
        low_then_high(3);
        pulse();
        cyc(60);
        chk("R5 no tick holds", drv_en, 1'b1);
        pulse();
        chk("R5 then drops", drv_en, 1'b0);
    endtask

    task automatic t_retrigger;
        hold_cfg = W'(4);
        low_then_high(3);
        pulse(); pulse(); pulse();
        chk("R6 mid countdown", drv_en, 1'b1);
        low_then_high(2);
        pulse(); pulse(); pulse();
        chk("R6 full hold restarted", drv_en, 1'b1);
        pulse();
        chk("R6 drop after full hold", drv_en, 1'b0);
    endtask

    task automatic t_zero_cfg;
        hold_cfg = W'(0);
        low_then_high(3);
        chk("R7 on with zero cfg", drv_en, 1'b1);
        pulse();
        chk("R7 off after one tick", drv_en, 1'b0);
    endtask

    task automatic t_max_cfg;
        hold_cfg = '1;
        low_then_high(3);
        for (int i = 0; i < (1 << W) - 2; i++) pulse();
        chk("R8 one tick left", drv_en, 1'b1);
        pulse();
        chk("R8 drop at max", drv_en, 1'b0);
    endtask

    // 8N1 character of 0xFF, 4 clk per bit, tick on last clk of each bit.
    task automatic t_frame;
        logic [9:0] frame;
        bit         held;
        int         after;
        hold_cfg = W'(10);
        frame = {1'b1, 8'hFF, 1'b0};
        held = 1'b1;
        for (int b = 0; b < 10; b++) begin
            txd = frame[b];
            for (int c = 0; c < 4; c++) begin
                tick = (c == 3);
                @(negedge clk);
                if (!(b == 0 && c < 3) && drv_en !== 1'b1) held = 1'b0;
            end
        end
        tick = 1'b0;
        chk("R9 held through stop bit", held, 1'b1);
        after = 0;
        while (drv_en === 1'b1 && after < 20) begin
            for (int c = 0; c < 4; c++) begin
                tick = (c == 3);
                @(negedge clk);
            end
            after++;
        end
        tick = 1'b0;
        chk("R9 off within a character", (after <= 10), 1'b1);
        chk("R9 finally off", drv_en, 1'b0);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_freeze();
        t_retrigger();
        t_zero_cfg();
        t_max_cfg();
        t_frame();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule